// File: doc/BRIEF.md
# PCI Bridge Configuration Cycle Router

This block sits on the upstream side of a PCI-to-PCI bridge. It inspects each configuration command that arrives from the primary bus and decides what the bridge does with it. The command's address, its read/write flag, the primary device-select input and the bridge's secondary and subordinate bus number registers together determine one of five outcomes. The bridge can claim the command for its own registers, ignore it, pass it downstream unchanged, rewrite it as a Type 0 command for a device on the secondary bus, or turn it into a Special Cycle broadcast there. The block also produces the address to drive on the secondary side.

Requests enter through a valid/ready handshake. A two-state controller governs the exchange. In `S_IDLE`, `req_ready` is high, and a request with `req_valid` takes transition `T_ACCEPT` into `S_HOLD` while the result is registered. In `S_HOLD`, the result is presented with `rsp_valid`. Transition `T_RELEASE` returns to `S_IDLE` on the first cycle that `rsp_ready` is high. Otherwise transition `T_WAIT` stays in `S_HOLD`.

Top module: `pcicfg_route`

## Requirements
- R1: Address bits [1:0] pick the format: 00 is Type 0 and 01 is Type 1. The values 10 and 11 always give disposition IGNORE with a translated address of zero. Disposition codes on `rsp_disp` are 0 CLAIM, 1 IGNORE, 2 FORWARD, 3 TYPE0, 4 SPECIAL.
- R2: A Type 0 command gives CLAIM with the address passed through unchanged when `idsel_in` is high. When `idsel_in` is low it gives IGNORE with a zero address.
- R3: A write of Type 1 format gives SPECIAL with a zero address when all of these hold: bus number (bits [23:16]) equals `sec_bus`, device (bits [15:11]) is 31, function (bits [10:8]) is 7 and register (bits [7:2]) is 0.
- R4: Any other Type 1 command whose bus number equals `sec_bus` gives TYPE0. Its address has bits [1:0] = 00, bits [10:2] copied, bits [15:11] zero, and bits [31:16] holding a single bit at position 16+device.
- R5: In a TYPE0 conversion with device number 16 to 31, bits [31:16] of the translated address are all zero.
- R6: A Type 1 command with bus number greater than `sec_bus` and at most `sub_bus` gives FORWARD with the address unchanged.
- R7: A Type 1 command with any other bus number gives IGNORE with a zero address.
- R8: `rsp_valid` rises on the clock edge after a request is accepted (`req_valid` and `req_ready` both high). `req_ready` stays low while `rsp_valid` is high, and both return to their idle values on the edge after `rsp_ready` is high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_disp` and `rsp_addr` do not change.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Configuration address from the primary bus |
| req_write | input | 1 | 1 for a write command, 0 for a read |
| idsel_in | input | 1 | Primary device-select input |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_disp | output | 3 | Disposition code |
| rsp_addr | output | 32 | Translated secondary-side address |

## Verification
The assertions assume that `sec_bus` and `sub_bus` are held steady while a request is in flight, and that `rsp_ready` is a plain level sampled at the clock. The bench changes the bus registers only between transactions and always keeps `sub_bus` at or above `sec_bus`. It drives every input half a cycle away from the sampling edge. The random addresses are biased so that the secondary, forwarded and out-of-range bus numbers, the reserved formats and the Special Cycle target each appear often.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
    localparam int ADDR_W      = 32;
    localparam int BUS_W       = 8;
    localparam int DEV_W       = 5;
    localparam int FN_W        = 3;
    localparam int REG_W       = 6;
    localparam int IDSEL_LINES = 16;
    localparam int IDSEL_LSB   = 16;
    localparam int DISP_W      = 3;

    localparam int REG_LSB = 2;
    localparam int FN_LSB  = REG_LSB + REG_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;

    localparam logic [DEV_W-1:0] SPC_DEV = '1;
    localparam logic [FN_W-1:0]  SPC_FN  = '1;
    localparam logic [REG_W-1:0] SPC_REG = '0;

    typedef enum logic [DISP_W-1:0] {
        DISP_CLAIM   = 3'd0,
        DISP_IGNORE  = 3'd1,
        DISP_FORWARD = 3'd2,
        DISP_TYPE0   = 3'd3,
        DISP_SPECIAL = 3'd4
    } disp_e;

    typedef enum logic [1:0] {
        FMT_TYPE0 = 2'b00,
        FMT_TYPE1 = 2'b01
    } fmt_e;
endpackage

// File: rtl/pcicfg_classify.sv
module pcicfg_classify
    import pcicfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              idsel,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output disp_e             disp
);
    logic [BUS_W-1:0] bus_num;
    logic [DEV_W-1:0] dev_num;
    logic [FN_W-1:0]  fn_num;
    logic [REG_W-1:0] reg_num;
    logic             on_sec;
    logic             in_range;
    logic             spc_hit;

    assign bus_num  = addr[BUS_LSB +: BUS_W];
    assign dev_num  = addr[DEV_LSB +: DEV_W];
    assign fn_num   = addr[FN_LSB +: FN_W];
    assign reg_num  = addr[REG_LSB +: REG_W];
    assign on_sec   = (bus_num == sec_bus);
    assign in_range = (bus_num > sec_bus) && (bus_num <= sub_bus);
    assign spc_hit  = is_write && (dev_num == SPC_DEV) &&
                      (fn_num == SPC_FN) && (reg_num == SPC_REG);

    always_comb begin
        disp = DISP_IGNORE;
        unique case (addr[1:0])
            FMT_TYPE0: disp = idsel ? DISP_CLAIM : DISP_IGNORE;
            FMT_TYPE1: begin
                if (on_sec)        disp = spc_hit ? DISP_SPECIAL : DISP_TYPE0;
                else if (in_range) disp = DISP_FORWARD;
                else               disp = DISP_IGNORE;
            end
            default:   disp = DISP_IGNORE;
        endcase
    end
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
    import pcicfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  disp_e             disp,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int KEEP_W = DEV_LSB - REG_LSB;
    localparam int GAP_W  = IDSEL_LSB - DEV_LSB;

    logic [DEV_W-1:0]       dev_num;
    logic [IDSEL_LINES-1:0] sel_lines;
    logic [ADDR_W-1:0]      t0_addr;

    assign dev_num = addr[DEV_LSB +: DEV_W];

    for (genvar g = 0; g < IDSEL_LINES; g++) begin : g_idsel
        assign sel_lines[g] = (dev_num == DEV_W'(g));
    end

    assign t0_addr = {sel_lines, {GAP_W{1'b0}}, addr[REG_LSB +: KEEP_W], 2'b00};

    always_comb begin
        unique case (disp)
            DISP_CLAIM, DISP_FORWARD: addr_out = addr;
            DISP_TYPE0:               addr_out = t0_addr;
            default:                  addr_out = '0;
        endcase
    end
endmodule

// File: rtl/pcicfg_route.sv
module pcicfg_route
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              idsel_in,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DISP_W-1:0] rsp_disp,
    output logic [ADDR_W-1:0] rsp_addr
);
    typedef enum logic {S_IDLE = 1'b0, S_HOLD = 1'b1} state_e;

    state_e            state_q, state_d;
    disp_e             disp_c;
    logic [ADDR_W-1:0] addr_c;
    disp_e             disp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    pcicfg_classify u_cls (
        .addr     (req_addr),
        .is_write (req_write),
        .idsel    (idsel_in),
        .sec_bus  (sec_bus),
        .sub_bus  (sub_bus),
        .disp     (disp_c)
    );

    pcicfg_xlate u_xl (
        .addr     (req_addr),
        .disp     (disp_c),
        .addr_out (addr_c)
    );

    assign accept = req_valid && (state_q == S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_HOLD;  // T_ACCEPT
            S_HOLD: if (rsp_ready) state_d = S_IDLE;  // T_RELEASE, else T_WAIT
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= DISP_IGNORE;
            addr_q <= '0;
        end else if (accept) begin
            disp_q <= disp_c;
            addr_q <= addr_c;
        end
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_HOLD);
        rsp_disp  = disp_q;
        rsp_addr  = addr_q;
    end

    // R10: idle values straight after reset
    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            p_reset_idle_r10: assert (!rsp_valid && req_ready)
                else $error("reset state wrong");
        end
    end

    p_valid_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_ready_low_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> ($stable(rsp_disp) && $stable(rsp_addr)));

    p_idsel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_disp == DISP_TYPE0) |->
            ($onehot0(rsp_addr[ADDR_W-1:IDSEL_LSB]) && rsp_addr[1:0] == 2'b00));

    p_ignore_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_disp == DISP_IGNORE || rsp_disp == DISP_SPECIAL)) |->
            (rsp_addr == '0));

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_disp <= DISP_SPECIAL));
endmodule

// File: tb/sim_pcicfg_route.sv
module sim_pcicfg_route;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        idsel_in = 1'b0;
    logic [7:0]  sec_bus = 8'd5;
    logic [7:0]  sub_bus = 8'd9;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [2:0]  rsp_disp;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pcicfg_route u0 (.*);

    function automatic logic [2:0] exp_disp(input logic [31:0] a, input logic w,
                                            input logic sel, input logic [7:0] s,
                                            input logic [7:0] u);
        logic [7:0] b = a[23:16];
        if (a[1:0] == 2'b00) return sel ? 3'd0 : 3'd1;
        if (a[1:0] != 2'b01) return 3'd1;
        if (b == s) begin
            if (w && a[15:11] == 5'd31 && a[10:8] == 3'd7 && a[7:2] == 6'd0) return 3'd4;
            return 3'd3;
        end
        if (b > s && b <= u) return 3'd2;
        return 3'd1;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [2:0] d);
        logic [31:0] r;
        case (d)
            3'd0, 3'd2: r = a;
            3'd3: begin
                r = a & 32'h0000_07FC;
                if (a[15:11] < 5'd16) r[16 + a[15:11]] = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic w, input logic sel,
                        input bit stall, input string req);
        logic [2:0]  ed;
        logic [31:0] ea;
        ed = exp_disp(a, w, sel, sec_bus, sub_bus);
        ea = exp_addr(a, ed);
        @(negedge clk);
        req_addr = a; req_write = w; idsel_in = sel; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        check(rsp_valid && !req_ready, "R8 valid/ready", {30'd0, rsp_valid, req_ready}, 32'h2);
        check(rsp_disp == ed, {req, " disp"}, 32'(rsp_disp), 32'(ed));
        check(rsp_addr == ea, {req, " addr"}, rsp_addr, ea);
        if (stall) begin
            @(negedge clk);
            check(rsp_valid && rsp_disp == ed && rsp_addr == ea, "R9 hold",
                  rsp_addr, ea);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R8 release", {30'd0, rsp_valid, req_ready}, 32'h1);
    endtask

    function automatic logic [31:0] t1(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [5:0] r);
        return {8'h00, b, d, f, r, 2'b01};
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!rsp_valid && req_ready, "R10 reset", {30'd0, rsp_valid, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R10 after reset", {30'd0, rsp_valid, req_ready}, 32'h1);

        send(32'hABCD_1234 & ~32'h3, 1'b0, 1'b1, 1'b0, "R2 claim");
        send(32'hABCD_1234 & ~32'h3, 1'b1, 1'b0, 1'b0, "R2 ignore");
        send(32'h0012_3402, 1'b1, 1'b1, 1'b0, "R1 fmt10");
        send(32'h0012_3403, 1'b0, 1'b1, 1'b0, "R1 fmt11");
        send(t1(8'd5, 5'd31, 3'd7, 6'd0), 1'b1, 1'b0, 1'b1, "R3 special");
        send(t1(8'd5, 5'd31, 3'd7, 6'd0), 1'b0, 1'b0, 1'b0, "R5 read dev31");
        send(t1(8'd5, 5'd31, 3'd7, 6'd1), 1'b1, 1'b0, 1'b0, "R3 reg1 not special");
        send(t1(8'd5, 5'd0, 3'd2, 6'd9), 1'b0, 1'b0, 1'b0, "R4 dev0");
        send(t1(8'd5, 5'd15, 3'd7, 6'd63), 1'b1, 1'b0, 1'b1, "R4 dev15");
        send(t1(8'd5, 5'd16, 3'd1, 6'd4), 1'b0, 1'b0, 1'b0, "R5 dev16");
        send(t1(8'd6, 5'd3, 3'd0, 6'd0), 1'b0, 1'b0, 1'b0, "R6 low edge");
        send(t1(8'd9, 5'd3, 3'd0, 6'd0) | 32'h5A00_0000, 1'b1, 1'b0, 1'b0, "R6 high edge");
        send(t1(8'd10, 5'd3, 3'd0, 6'd0), 1'b0, 1'b0, 1'b0, "R7 above sub");
        send(t1(8'd4, 5'd3, 3'd0, 6'd0), 1'b0, 1'b0, 1'b0, "R7 below sec");
        send(t1(8'd0, 5'd3, 3'd0, 6'd0), 1'b0, 1'b0, 1'b0, "R7 bus0");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [7:0]  b;
            int          pick;
            if (i % 50 == 0) begin
                sec_bus = 8'($urandom_range(0, 200));
                sub_bus = sec_bus + 8'($urandom_range(0, 40));
            end
            a = $urandom();
            pick = $urandom_range(0, 5);
            case (pick)
                0: b = sec_bus;
                1: b = sec_bus + 8'($urandom_range(0, 3));
                2: b = sub_bus;
                3: b = sub_bus + 8'd1;
                default: b = a[23:16];
            endcase
            a[23:16] = b;
            if ($urandom_range(0, 7) == 0) a[15:2] = 14'h3FC0;
            a[1:0] = ($urandom_range(0, 3) != 0) ? 2'b01 : 2'($urandom_range(0, 3));
            send(a, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), "R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule